// File: doc/BRIEF.md
# Boundary-Mode PFC Switch Timing Controller

This block decides, clock cycle by clock cycle, when the switch of a boost power factor corrector turns on and off. It takes already-digitized comparator flags (end of demagnetization, auxiliary-winding tops, peak overcurrent, boost overvoltage, boost too low, mains brownout, mains good, soft-stop finished, run request) plus a requested on-time word from the voltage loop. It drives one gate signal. Every timing limit is counted in clock cycles.

After each on-stroke the block waits for the inductor to demagnetize. It then turns on at the next rising edge of the valley flag, which marks a minimum of the drain voltage. If demagnetization never comes, a 50 us timeout forces the switch on. If demagnetization came but no valley follows, a 4 us timeout forces it on. A minimum off-time and a minimum switching period are always honoured. When a valley arrives too early for these limits, it is skipped and a later valley is used, which gives discontinuous conduction at light load. Overcurrent cuts the on-stroke short once a leading-edge blanking window has passed. A status word reports what started the most recent stroke.

Top module: `pfc_gate_timer`

## Requirements
- R1: After reset `gate` is low and `start_cause` reads 0.
- R2: No stroke starts until `mains_ok_a` has been seen. A brownout takes `gate` low within three clock cycles. After a brownout, switching stays off until `mains_ok_a` is seen again, even once the brownout clears.
- R3: While `ton_req` is zero, no gate pulse is produced.
- R4: Without overcurrent, each gate pulse is high for exactly `ton_req` cycles, using the value sampled when the stroke starts. A stroke started from the stopped state reports `start_cause` = 0.
- R5: A synchronized overcurrent ends the pulse at the first edge after the first LEB_CYC cycles of the on-time. With overcurrent held high, the pulse is therefore LEB_CYC+1 cycles wide.
- R6: When demagnetization is followed by a valley rising edge, and the minimum off-time and minimum period are met, the stroke starts on that edge and `start_cause` = 1.
- R7: If no demagnetization is seen within 50 us of `gate` falling (CLK_HZ/20000 cycles), the switch is forced on and `start_cause` = 2.
- R8: If demagnetization is seen but no valley edge follows within 4 us (CLK_HZ/250000 cycles), the switch is forced on and `start_cause` = 3.
- R9: Gate low time between two pulses is never below MIN_OFF_CYC cycles. A valley that comes earlier is skipped.
- R10: The time from one rising gate edge to the next is never below PERIOD_MIN_CYC cycles. A valley that comes earlier is skipped, and a later valley is used.
- R11: Boost overvoltage ends any pulse and blocks starts. Once it clears, switching resumes with no other action needed.
- R12: While the boost-too-low flag is set, no stroke starts. Switching begins once the flag clears.
- R13: After the run request drops, switching continues until soft-stop-done is set. Switching then stops, and it resumes when the run request returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| demag_a | input | 1 | Demagnetization detected (asynchronous) |
| valley_a | input | 1 | Auxiliary-winding top seen; its rising edge is used (asynchronous) |
| ocp_a | input | 1 | Peak overcurrent (asynchronous) |
| ovp_a | input | 1 | Boost overvoltage (asynchronous) |
| boost_low_a | input | 1 | Boost too low / open loop (asynchronous) |
| brownout_a | input | 1 | Mains brownout (asynchronous) |
| mains_ok_a | input | 1 | Mains start level reached (asynchronous) |
| run_req_a | input | 1 | Burst/enable run request (asynchronous) |
| ss_done_a | input | 1 | Soft-stop finished (asynchronous) |
| ton_req | input | TON_W | Requested on-time in cycles, synchronous to clk |
| gate | output | 1 | Switch gate command |
| start_cause | output | 2 | Cause of the last start: 0 restart, 1 valley, 2 demag timeout, 3 valley timeout |

## Verification
The bench drives a behavioural inductor model that raises demagnetization and a train of valley pulses at set delays after each gate fall. This lets it place valleys before and after the minimum off-time and the minimum period. A design that failed to skip early valleys would show a shortened low time or period. A design that dropped the skipped-valley path would instead fall back to the valley timeout and report cause 3 where cause 1 is expected. Holding overcurrent high through a stroke checks the blanking edge exactly: an off-by-one there changes the pulse width. The two timeouts are checked separately, so a swapped or shared timeout counter shows up as a wrong low time or a wrong cause. The protection flags, the soft-stop handshake and a zero on-time request are each checked to stop pulses and then to allow a clean restart.

// File: rtl/pfc_gate_pkg.sv
`timescale 1ns/1ps
package pfc_gate_pkg;

  typedef enum logic [1:0] {
    CAUSE_KICK     = 2'd0,
    CAUSE_VALLEY   = 2'd1,
    CAUSE_DEMAG_TO = 2'd2,
    CAUSE_VALLEY_TO= 2'd3
  } start_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ON      = 2'd1,
    ST_WDEMAG  = 2'd2,
    ST_WVALLEY = 2'd3
  } stroke_st_e;

  // cycles in a span of whole microseconds; clock assumed a multiple of 1 MHz
  function automatic int unsigned us_to_cyc(int unsigned hz, int unsigned us);
    return (hz / 1_000_000) * us;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // width able to hold n plus headroom for saturation
  function automatic int unsigned cnt_bits(int unsigned n);
    return $clog2(n + 2);
  endfunction

endpackage

// File: rtl/pfc_sync.sv
`timescale 1ns/1ps
module pfc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= d_async[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign q_sync = stage2;

endmodule

// File: rtl/pfc_run_permit.sv
`timescale 1ns/1ps
module pfc_run_permit (
  input  logic clk,
  input  logic rst_n,
  input  logic s_brownout,
  input  logic s_mains_ok,
  input  logic s_ovp,
  input  logic s_boost_low,
  input  logic s_run,
  input  logic s_ss_done,
  output logic allow
);

  logic mains_armed_q;
  logic burst_keep;

  // arming latch: brownout wins, mains-good re-arms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mains_armed_q <= 1'b0;
    else if (s_brownout) mains_armed_q <= 1'b0;
    else if (s_mains_ok) mains_armed_q <= 1'b1;
  end

  // keep switching while running, or while soft stop is still in progress
  assign burst_keep = s_run | ~s_ss_done;

  assign allow = mains_armed_q & ~s_brownout & ~s_ovp & ~s_boost_low & burst_keep;

  AST_BROWNOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_brownout && !s_mains_ok) |=> !allow) else $error("brownout left switching armed"); // R2

endmodule

// File: rtl/pfc_stroke_seq.sv
`timescale 1ns/1ps
module pfc_stroke_seq
  import pfc_gate_pkg::*;
#(
  parameter int unsigned TON_W          = 8,
  parameter int unsigned MIN_OFF_CYC    = 16,
  parameter int unsigned PERIOD_MIN_CYC = 100,
  parameter int unsigned LEB_CYC        = 6,
  parameter int unsigned DTO_CYC        = 500,
  parameter int unsigned VTO_CYC        = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic             s_demag,
  input  logic             s_valley,
  input  logic             s_ocp,
  input  logic [TON_W-1:0] ton_req,
  output logic             gate,
  output logic [1:0]       cause
);

  localparam int unsigned OFF_LIM = max2(DTO_CYC, MIN_OFF_CYC);
  localparam int unsigned OFF_W   = cnt_bits(OFF_LIM);
  localparam int unsigned PER_W   = cnt_bits(PERIOD_MIN_CYC);
  localparam int unsigned VTO_W   = cnt_bits(VTO_CYC);

  localparam logic [OFF_W-1:0] OFF_MAX  = OFF_W'(OFF_LIM);
  localparam logic [OFF_W-1:0] OFF_MIN  = OFF_W'(MIN_OFF_CYC);
  localparam logic [OFF_W-1:0] DTO_V    = OFF_W'(DTO_CYC);
  localparam logic [PER_W-1:0] PER_MAX  = PER_W'(PERIOD_MIN_CYC);
  localparam logic [VTO_W-1:0] VTO_MAX  = VTO_W'(VTO_CYC);
  localparam logic [TON_W-1:0] LEB_V    = TON_W'(LEB_CYC);

  stroke_st_e       st_q;
  start_cause_e     cause_q, cause_nxt;
  logic             gate_q;
  logic [TON_W-1:0] on_cnt, ton_lat;
  logic [OFF_W-1:0] off_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [VTO_W-1:0] vto_cnt;
  logic             valley_d;

  // named internal events
  logic v_rise, ton_nz, spacing_ok, start_ok;
  logic ev_dto, ev_vto, ev_leb_over, ev_ocp_cut, ev_on_done, on_end, ev_start;

  assign v_rise      = s_valley & ~valley_d;
  assign ton_nz      = |ton_req;
  assign spacing_ok  = (off_cnt >= OFF_MIN) && (per_cnt >= PER_MAX);
  assign start_ok    = allow && ton_nz && spacing_ok;
  assign ev_dto      = (st_q == ST_WDEMAG)  && (off_cnt >= DTO_V);
  assign ev_vto      = (st_q == ST_WVALLEY) && (vto_cnt >= VTO_MAX);
  assign ev_leb_over = on_cnt > LEB_V;
  assign ev_ocp_cut  = s_ocp && ev_leb_over;
  assign ev_on_done  = on_cnt >= ton_lat;
  assign on_end      = ev_on_done || ev_ocp_cut || !allow;

  always_comb begin
    ev_start  = 1'b0;
    cause_nxt = CAUSE_KICK;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) ev_start = 1'b1;
      end
      ST_WDEMAG: begin
        if (start_ok && ev_dto && !s_demag) begin
          ev_start  = 1'b1;
          cause_nxt = CAUSE_DEMAG_TO;
        end
      end
      ST_WVALLEY: begin
        if (start_ok && v_rise) begin
          ev_start  = 1'b1;
          cause_nxt = CAUSE_VALLEY;
        end else if (start_ok && ev_vto) begin
          ev_start  = 1'b1;
          cause_nxt = CAUSE_VALLEY_TO;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      gate_q   <= 1'b0;
      on_cnt   <= '0;
      ton_lat  <= '0;
      off_cnt  <= OFF_MAX;
      per_cnt  <= PER_MAX;
      vto_cnt  <= '0;
      cause_q  <= CAUSE_KICK;
      valley_d <= 1'b0;
    end else begin
      valley_d <= s_valley;
      if (per_cnt != PER_MAX) per_cnt <= per_cnt + 1'b1;
      if (st_q != ST_ON && off_cnt != OFF_MAX) off_cnt <= off_cnt + 1'b1;
      if (st_q == ST_WVALLEY && vto_cnt != VTO_MAX) vto_cnt <= vto_cnt + 1'b1;
      if (ev_start) begin
        st_q    <= ST_ON;
        gate_q  <= 1'b1;
        on_cnt  <= TON_W'(1);
        ton_lat <= ton_req;
        per_cnt <= '0;
        cause_q <= cause_nxt;
      end else begin
        unique case (st_q)
          ST_ON: begin
            on_cnt <= on_cnt + 1'b1;
            if (on_end) begin
              gate_q  <= 1'b0;
              off_cnt <= '0;
              st_q    <= allow ? ST_WDEMAG : ST_IDLE;
            end
          end
          ST_WDEMAG: begin
            if (!allow) st_q <= ST_IDLE;
            else if (s_demag) begin
              st_q    <= ST_WVALLEY;
              vto_cnt <= '0;
            end
          end
          ST_WVALLEY: begin
            if (!allow) st_q <= ST_IDLE;
            else if (v_rise) vto_cnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign gate  = gate_q;
  assign cause = cause_q;

  // checker-only spacing counters, independent of the sequencer counters
  logic [OFF_W-1:0] chk_low;
  logic [PER_W-1:0] chk_per;
  logic             chk_gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low    <= OFF_MAX;
      chk_per    <= PER_MAX;
      chk_gate_d <= 1'b0;
    end else begin
      chk_gate_d <= gate_q;
      if (gate_q) chk_low <= '0;
      else if (chk_low != OFF_MAX) chk_low <= chk_low + 1'b1;
      if (gate_q && !chk_gate_d) chk_per <= PER_W'(1);
      else if (chk_per != PER_MAX) chk_per <= chk_per + 1'b1;
    end
  end

  AST_MIN_OFF_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (chk_low >= OFF_MIN)) else $error("off-time below minimum"); // R9
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (chk_per >= PER_MAX)) else $error("period below minimum"); // R10
  AST_OCP_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && s_ocp && chk_per > PER_W'(LEB_CYC) && !$rose(gate_q)) |=> !gate_q)
    else $error("overcurrent ignored after blanking"); // R5

endmodule

// File: rtl/pfc_gate_timer.sv
`timescale 1ns/1ps
module pfc_gate_timer
  import pfc_gate_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 10_000_000,
  parameter int unsigned TON_W          = 8,
  parameter int unsigned MIN_OFF_CYC    = 16,
  parameter int unsigned PERIOD_MIN_CYC = 100,
  parameter int unsigned LEB_CYC        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             demag_a,
  input  logic             valley_a,
  input  logic             ocp_a,
  input  logic             ovp_a,
  input  logic             boost_low_a,
  input  logic             brownout_a,
  input  logic             mains_ok_a,
  input  logic             run_req_a,
  input  logic             ss_done_a,
  input  logic [TON_W-1:0] ton_req,
  output logic             gate,
  output logic [1:0]       start_cause
);

  localparam int unsigned DTO_CYC = us_to_cyc(CLK_HZ, 50);
  localparam int unsigned VTO_CYC = us_to_cyc(CLK_HZ, 4);
  localparam int unsigned N_FLAGS = 9;

  localparam int unsigned IX_DEMAG = 0;
  localparam int unsigned IX_VAL   = 1;
  localparam int unsigned IX_OCP   = 2;
  localparam int unsigned IX_OVP   = 3;
  localparam int unsigned IX_BLOW  = 4;
  localparam int unsigned IX_BRN   = 5;
  localparam int unsigned IX_MOK   = 6;
  localparam int unsigned IX_RUN   = 7;
  localparam int unsigned IX_SSD   = 8;

  logic [N_FLAGS-1:0] raw_flags, s_flags;
  logic allow;
  logic gate_int;

  assign raw_flags = {ss_done_a, run_req_a, mains_ok_a, brownout_a, boost_low_a,
                      ovp_a, ocp_a, valley_a, demag_a};

  pfc_sync #(.W(N_FLAGS)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_flags),
    .q_sync  (s_flags)
  );

  pfc_run_permit permit_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_brownout  (s_flags[IX_BRN]),
    .s_mains_ok  (s_flags[IX_MOK]),
    .s_ovp       (s_flags[IX_OVP]),
    .s_boost_low (s_flags[IX_BLOW]),
    .s_run       (s_flags[IX_RUN]),
    .s_ss_done   (s_flags[IX_SSD]),
    .allow       (allow)
  );

  pfc_stroke_seq #(
    .TON_W          (TON_W),
    .MIN_OFF_CYC    (MIN_OFF_CYC),
    .PERIOD_MIN_CYC (PERIOD_MIN_CYC),
    .LEB_CYC        (LEB_CYC),
    .DTO_CYC        (DTO_CYC),
    .VTO_CYC        (VTO_CYC)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .allow    (allow),
    .s_demag  (s_flags[IX_DEMAG]),
    .s_valley (s_flags[IX_VAL]),
    .s_ocp    (s_flags[IX_OCP]),
    .ton_req  (ton_req),
    .gate     (gate_int),
    .cause    (start_cause)
  );

  assign gate = gate_int;

  AST_BROWNOUT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    s_flags[IX_BRN] |=> !gate_int) else $error("gate high after brownout"); // R2
  AST_OVP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    s_flags[IX_OVP] |=> !gate_int) else $error("gate high during overvoltage"); // R11
  AST_BOOST_LOW_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (s_flags[IX_BLOW] && !gate_int) |=> !gate_int) else $error("start with boost low"); // R12
  AST_ZERO_TON_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_int) |-> ($past(ton_req) != '0)) else $error("pulse on zero on-time"); // R3

endmodule

// File: tb/pfc_gate_timer_tb_top.sv
`timescale 1ns/1ps
module pfc_gate_timer_tb_top;

  localparam int CLK_PERIOD = 100;
  localparam int CLK_HZ     = 10_000_000;
  localparam int TON_W      = 8;
  localparam int MIN_OFF    = 16;
  localparam int PER_MIN    = 100;
  localparam int LEB        = 6;
  localparam int DTO        = 50 * (CLK_HZ / 1_000_000);
  localparam int VTO        = 4 * (CLK_HZ / 1_000_000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic demag_a = 1'b0, valley_a = 1'b0, ocp_a = 1'b0, ovp_a = 1'b0;
  logic boost_low_a = 1'b0, brownout_a = 1'b0, mains_ok_a = 1'b0;
  logic run_req_a = 1'b1, ss_done_a = 1'b0;
  logic [TON_W-1:0] ton_req = 8'd90;
  logic gate;
  logic [1:0] start_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_gate_timer #(
    .CLK_HZ(CLK_HZ), .TON_W(TON_W), .MIN_OFF_CYC(MIN_OFF),
    .PERIOD_MIN_CYC(PER_MIN), .LEB_CYC(LEB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .demag_a(demag_a), .valley_a(valley_a),
    .ocp_a(ocp_a), .ovp_a(ovp_a), .boost_low_a(boost_low_a),
    .brownout_a(brownout_a), .mains_ok_a(mains_ok_a), .run_req_a(run_req_a),
    .ss_done_a(ss_done_a), .ton_req(ton_req), .gate(gate), .start_cause(start_cause)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct {
    int    cause;
    int    wmin, wmax, lmin, lmax;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // inductor model settings
  bit en_demag = 1'b1, en_valley = 1'b1;
  int d_dly = 10, v_ofs = 8, v_per = 12;
  int low_k = 0;

  always @(negedge clk) begin
    if (gate || !rst_n) begin
      low_k    = 0;
      demag_a  <= 1'b0;
      valley_a <= 1'b0;
    end else begin
      low_k = low_k + 1;
      demag_a <= en_demag && (low_k >= d_dly);
      valley_a <= en_demag && en_valley && (low_k >= d_dly + v_ofs) &&
                  (((low_k - d_dly - v_ofs) % v_per) < 2);
    end
  end

  // monitor: measure each pulse and compare against the scoreboard
  int rises = 0;
  int lo_run = 0, hi_run = 0, m_low = 0, m_cause = 0;
  bit g_prev = 1'b0;

  task automatic note(input bit ok, input string tag, input string what, input int act,
                      input int emin, input int emax);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d..%0d", tag, what, act, emin, emax);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (gate) begin
        if (!g_prev) begin
          m_low   = lo_run;
          m_cause = int'(start_cause);
          hi_run  = 0;
          rises++;
        end
        hi_run++;
        lo_run = 0;
      end else begin
        if (g_prev && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          note(hi_run >= e.wmin && hi_run <= e.wmax, e.tag, "width", hi_run, e.wmin, e.wmax);
          note(m_low >= e.lmin && m_low <= e.lmax, e.tag, "low", m_low, e.lmin, e.lmax);
          if (e.cause >= 0)
            note(m_cause == e.cause, e.tag, "cause", m_cause, e.cause, e.cause);
        end
        lo_run++;
      end
      g_prev = gate;
    end
  end

  task automatic push(input int cause, input int wmin, input int wmax,
                      input int lmin, input int lmax, input string tag);
    exp_t e;
    e.cause = cause; e.wmin = wmin; e.wmax = wmax;
    e.lmin = lmin; e.lmax = lmax; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (exp_q.size() > 0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() > 0) begin
      note(1'b0, tag, "pending_pulses", exp_q.size(), 0, 0);
      exp_q.delete();
    end
  endtask

  task automatic skip_pulses(input int n);
    int base = rises;
    int c = 0;
    while (rises < base + n && c < 3000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic quiet_check(input int cycles, input string tag);
    int base = rises;
    repeat (cycles) @(negedge clk);
    note(rises == base, tag, "new_pulses", rises - base, 0, 0);
  endtask

  task automatic gate_low_check(input string tag);
    repeat (5) @(negedge clk);
    note(gate == 1'b0, tag, "gate", int'(gate), 0, 0);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    note(gate == 1'b0, "R1", "gate", int'(gate), 0, 0);
    note(start_cause == 2'd0, "R1", "cause", int'(start_cause), 0, 0);
    rst_n = 1'b1;

    // R2 nothing before mains good
    quiet_check(200, "R2");

    // R4/R6 quasi-resonant operation: first start is a restart, then valleys
    push(0, 90, 90, 0, 100000, "R4");
    push(1, 90, 90, 18, 22, "R6");
    push(1, 90, 90, 18, 22, "R6");
    mains_ok_a = 1'b1;
    wait_drain("R6");

    // R10 short on-time: early valleys skipped until the period allows
    ton_req = 8'd30;
    skip_pulses(2);
    push(1, 30, 30, 71, 87, "R10");
    push(1, 30, 30, 71, 87, "R10");
    wait_drain("R10");

    // R8 valley timeout
    ton_req = 8'd90; en_valley = 1'b0;
    skip_pulses(2);
    push(3, 90, 90, 10 + VTO, 10 + VTO + 5, "R8");
    push(3, 90, 90, 10 + VTO, 10 + VTO + 5, "R8");
    wait_drain("R8");

    // R7 demagnetization timeout
    en_demag = 1'b0;
    skip_pulses(1);
    push(2, 90, 90, DTO, DTO + 3, "R7");
    push(2, 90, 90, DTO, DTO + 3, "R7");
    wait_drain("R7");

    // R9 valleys arrive before the minimum off-time
    en_demag = 1'b1; en_valley = 1'b1;
    d_dly = 1; v_ofs = 1; v_per = 4; ton_req = 8'd95;
    skip_pulses(2);
    push(1, 95, 95, MIN_OFF + 1, MIN_OFF + 9, "R9");
    push(1, 95, 95, MIN_OFF + 1, MIN_OFF + 9, "R9");
    wait_drain("R9");

    // R5 overcurrent held through the stroke
    d_dly = 10; v_ofs = 8; v_per = 12; ton_req = 8'd60;
    ocp_a = 1'b1;
    skip_pulses(2);
    push(1, LEB + 1, LEB + 1, 0, 100000, "R5");
    push(1, LEB + 1, LEB + 1, 0, 100000, "R5");
    wait_drain("R5");
    ocp_a = 1'b0;
    ton_req = 8'd90;
    skip_pulses(2);

    // R3 zero on-time request
    ton_req = 8'd0;
    repeat (150) @(negedge clk);
    quiet_check(700, "R3");
    note(gate == 1'b0, "R3", "gate", int'(gate), 0, 0);
    ton_req = 8'd90;
    skip_pulses(2);

    // R11 boost overvoltage
    ovp_a = 1'b1;
    gate_low_check("R11");
    quiet_check(600, "R11");
    push(0, 90, 90, 0, 100000, "R11");
    ovp_a = 1'b0;
    wait_drain("R11");

    // R12 boost too low
    boost_low_a = 1'b1;
    gate_low_check("R12");
    quiet_check(600, "R12");
    push(0, 90, 90, 0, 100000, "R12");
    boost_low_a = 1'b0;
    wait_drain("R12");

    // R2 brownout then re-arm
    mains_ok_a = 1'b0;
    brownout_a = 1'b1;
    gate_low_check("R2");
    brownout_a = 1'b0;
    quiet_check(600, "R2");
    push(0, 90, 90, 0, 100000, "R2");
    mains_ok_a = 1'b1;
    wait_drain("R2");

    // R13 soft stop handshake
    run_req_a = 1'b0;
    begin
      int base = rises;
      repeat (700) @(negedge clk);
      note(rises > base, "R13", "pulses_during_softstop", rises - base, 1, 100);
    end
    ss_done_a = 1'b1;
    gate_low_check("R13");
    quiet_check(600, "R13");
    push(0, 90, 90, 0, 100000, "R13");
    run_req_a = 1'b1;
    wait_drain("R13");

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule